// File: doc/BRIEF.md
# FIFO-Fed SPI Bus Master

This block is a serial peripheral bus master for byte-wide transfers. Software, or a local controller, pushes bytes into a transmit queue. The block shifts each byte out on MOSI, most significant bit first, and at the same time shifts one byte in from MISO. Each received byte goes into a receive queue that the host drains. Every byte sent produces exactly one byte received.

A set of static configuration inputs controls the transfer:
- The clock idle level and the sampling phase.
- The SCLK divider code.
- The slave-select value and how it is presented: a one-hot active-low line, or a binary code for an external decoder.
- Whether the select follows the queue level or is forced on.
- Whether words start on their own or wait for a start strobe.

An enable register, written through a strobe, gates all activity. A separate slave-select input watches for another master on the bus. If that input falls while the block is enabled, this is a mode fault. The block clears its enable, stops the word in flight at once and keeps that word queued, so it is resent in full once the host enables the block again.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, all `ss_n` lines are high, `sclk` is 0, `dev_en` is 0, `mode_fault` is 0, and both queues are empty.
- R2: Each queued byte is sent MSB first as 8 bits. Exactly one received byte, assembled MSB first from `miso`, is pushed to the receive queue for it, in order.
- R3: `sclk` rests at `cfg_cpol` whenever no word is in flight. It is low at rest for `cfg_cpol`=0 and high at rest for `cfg_cpol`=1.
- R4: With `cfg_cpha`=0, `mosi` holds the first bit before the first SCLK edge, and both sides sample on the 1st, 3rd, … edges. With `cfg_cpha`=1, data changes on those edges and is sampled on the 2nd, 4th, … edges.
- R5: The time between SCLK edges within a word is 2^k `clk` cycles for a prescale code k of 1 to 7. Code 0 behaves like code 1, which is 2 cycles (an SCLK period of clk/4).
- R6: With `cfg_force_cs`=0, the selected slave line is active exactly while the block is enabled and the transmit queue is not empty. SCLK only toggles during such a period.
- R7: With `cfg_force_cs`=1 and the block enabled, the selected slave line is active even with no data queued.
- R8: With `cfg_manual_start`=0, a word begins whenever the enabled block is idle and the transmit queue holds data. Transfer stalls when the queue is empty.
- R9: With `cfg_manual_start`=1, no word begins until `start_cmd` pulses. One pulse sends the queue until it runs empty. Data queued after that needs a new pulse.
- R10: With `cfg_decode`=0, an active select drives only `ss_n[cfg_sel]` low for `cfg_sel` in 0..2. A `cfg_sel` of 3 or more drives no line low. At most one line is ever low.
- R11: With `cfg_decode`=1, an active select drives `ss_n` = `cfg_sel` as a binary code, and an inactive one drives 3'b111 (code 7 means no slave).
- R12: If `ss_in_n` is low (after a 2-stage synchroniser) while enabled, `dev_en` clears and `mode_fault` pulses for one cycle. `sclk` returns to rest and the word in flight produces no received byte.
- R13: After a mode fault, `dev_en` stays 0 until `en_wr` writes 1. The aborted byte is then sent again from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | SCLK rest level |
| cfg_cpha | input | 1 | Sampling phase select |
| cfg_decode | input | 1 | 1: binary select code for external decoder |
| cfg_force_cs | input | 1 | 1: select held active while enabled |
| cfg_manual_start | input | 1 | 1: words wait for a start strobe |
| cfg_prescale | input | 3 | SCLK divider code |
| cfg_sel | input | 3 | Slave-select value |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 1 | Value written to the enable |
| start_cmd | input | 1 | Start strobe for manual start |
| tx_push | input | 1 | Write a byte into the transmit queue |
| tx_data | input | 8 | Byte to queue |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | 8 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| dev_en | output | 1 | Current enable state |
| mode_fault | output | 1 | One-cycle pulse on a mode fault |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 3 | Active-low slave selects or decoder code |
| miso | input | 1 | Serial data in |
| ss_in_n | input | 1 | External select input for fault detection |

## Verification
The checker watches the following on every cycle:
- No two one-hot select lines are low at once.
- A mode-fault pulse always coincides with a cleared enable.
- The enable cannot come back without a write.
- SCLK stays at its rest level while disabled.
- SCLK only moves while the transmit queue holds the word.

The bench has to show the rest through scenarios:
- Bit order and phase under all four clock formats, checked by a slave model that samples and drives on the actual SCLK edges.
- Edge spacing for several divider codes.
- The start-strobe gating.
- The decoder and forced-select patterns.
- The full resend of an aborted byte.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

    localparam int BYTE_W = 8;
    localparam int NSS    = 3;
    localparam int DIV_W  = 8;

    typedef struct packed {
        logic           cpol;
        logic           cpha;
        logic           decode;
        logic           force_cs;
        logic           manual_start;
        logic [2:0]     presc;
        logic [NSS-1:0] sel;
    } sfm_cfg_t;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_t;

    // clk cycles between SCLK edges for a divider code
    function automatic logic [DIV_W-1:0] half_period(input logic [2:0] code);
        if (code <= 3'd1) return DIV_W'(2);
        return DIV_W'(1) << code;
    endfunction

    // active-low select lines for the current mode
    function automatic logic [NSS-1:0] ss_pattern(input logic act,
                                                  input logic dec,
                                                  input logic [NSS-1:0] sel);
        logic [NSS-1:0] v;
        v = '1;
        if (act) begin
            if (dec) begin
                v = sel;
            end else begin
                for (int i = 0; i < NSS; i++) begin
                    if (sel == NSS'(i)) v[i] = 1'b0;
                end
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/sfm_fifo.sv
module sfm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == (AW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + (AW+1)'(1);
                2'b01:   cnt <= cnt - (AW+1)'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/sfm_sclk_div.sv
module sfm_sclk_div #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [DW-1:0] half,
    output logic          tick
);
    logic [DW-1:0] cnt;
    logic          at_end;

    assign at_end = (cnt == half - DW'(1));
    assign tick   = run && at_end;

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (at_end)  cnt <= '0;
        else              cnt <= cnt + DW'(1);
    end
endmodule

// File: rtl/sfm_shift_engine.sv
module sfm_shift_engine
    import sfm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         load,
    input  logic         abort,
    input  logic         tick,
    input  logic [W-1:0] tx_byte,
    input  logic         miso,
    output logic         sclk,
    output logic         mosi,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] rx_byte
);
    localparam int EDGES = 2 * W;
    localparam int EW    = $clog2(EDGES);

    eng_state_t    state;
    logic [EW-1:0] e;
    logic          ph;
    logic [W-1:0]  tx_sh, rx_sh, rx_next;
    logic          sample, last, first_drive;

    assign sample      = (e[0] == cpha);
    assign last        = (e == EW'(EDGES - 1));
    assign first_drive = cpha && (e == '0);
    assign rx_next     = {rx_sh[W-2:0], miso};
    assign sclk        = cpol ^ ph;
    assign mosi        = tx_sh[W-1];
    assign busy        = (state == ENG_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ENG_IDLE;
            e       <= '0;
            ph      <= 1'b0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                state <= ENG_IDLE;
                e     <= '0;
                ph    <= 1'b0;
            end else if (state == ENG_IDLE) begin
                if (load) begin
                    state <= ENG_RUN;
                    e     <= '0;
                    ph    <= 1'b0;
                    tx_sh <= tx_byte;
                end
            end else if (tick) begin
                ph <= ~ph;
                e  <= e + EW'(1);
                if (sample) rx_sh <= rx_next;
                if (!sample && !last && !first_drive) tx_sh <= tx_sh << 1;
                if (last) begin
                    state   <= ENG_IDLE;
                    done    <= 1'b1;
                    rx_byte <= sample ? rx_next : rx_sh;
                end
            end
        end
    end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import sfm_pkg::*;
#(
    parameter int TX_DEPTH    = 8,
    parameter int RX_DEPTH    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_decode,
    input  logic              cfg_force_cs,
    input  logic              cfg_manual_start,
    input  logic [2:0]        cfg_prescale,
    input  logic [NSS-1:0]    cfg_sel,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic              start_cmd,
    input  logic              tx_push,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_full,
    output logic              tx_empty,
    input  logic              rx_pop,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_empty,
    output logic              dev_en,
    output logic              mode_fault,
    output logic              sclk,
    output logic              mosi,
    output logic [NSS-1:0]    ss_n,
    input  logic              miso,
    input  logic              ss_in_n
);
    sfm_cfg_t cfg;
    assign cfg = '{cpol: cfg_cpol, cpha: cfg_cpha, decode: cfg_decode,
                   force_cs: cfg_force_cs, manual_start: cfg_manual_start,
                   presc: cfg_prescale, sel: cfg_sel};

    logic [SYNC_STAGES-1:0] ss_sync;
    logic                   fault_hit;
    logic                   armed;
    logic                   eng_busy, eng_done, eng_tick, go;
    logic [BYTE_W-1:0]      tx_head, rx_word;
    logic                   sel_active;

    // external select synchroniser
    always_ff @(posedge clk) begin
        if (rst) ss_sync <= '1;
        else     ss_sync <= {ss_sync[SYNC_STAGES-2:0], ss_in_n};
    end

    assign fault_hit = dev_en && !ss_sync[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_en     <= 1'b0;
            mode_fault <= 1'b0;
        end else begin
            mode_fault <= fault_hit;
            if (fault_hit)  dev_en <= 1'b0;
            else if (en_wr) dev_en <= en_wdata;
        end
    end

    // start arming for manual mode: one strobe drains the queue
    always_ff @(posedge clk) begin
        if (rst)                                        armed <= 1'b0;
        else if (start_cmd)                             armed <= 1'b1;
        else if (!eng_busy && !eng_done && tx_empty)    armed <= 1'b0;
    end

    assign go = dev_en && !fault_hit && !eng_busy && !eng_done && !tx_empty
             && (!cfg.manual_start || armed);

    // head is popped only when its word completes, so an abort keeps it
    sfm_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_push),
        .wdata (tx_data),
        .pop   (eng_done),
        .rdata (tx_head),
        .full  (tx_full),
        .empty (tx_empty)
    );

    sfm_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .push  (eng_done),
        .wdata (rx_word),
        .pop   (rx_pop),
        .rdata (rx_data),
        .full  (),
        .empty (rx_empty)
    );

    sfm_sclk_div #(.DW(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (eng_busy),
        .half (half_period(cfg.presc)),
        .tick (eng_tick)
    );

    sfm_shift_engine #(.W(BYTE_W)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .cpol    (cfg.cpol),
        .cpha    (cfg.cpha),
        .load    (go),
        .abort   (fault_hit || !dev_en),
        .tick    (eng_tick),
        .tx_byte (tx_head),
        .miso    (miso),
        .sclk    (sclk),
        .mosi    (mosi),
        .busy    (eng_busy),
        .done    (eng_done),
        .rx_byte (rx_word)
    );

    assign sel_active = dev_en && (cfg.force_cs || !tx_empty);
    assign ss_n       = ss_pattern(sel_active, cfg.decode, cfg.sel);

endmodule

// File: rtl/sfm_checker.sv
module sfm_checker
    import sfm_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           cfg_cpol,
    input logic           cfg_decode,
    input logic           en_wr,
    input logic           dev_en,
    input logic           mode_fault,
    input logic           sclk,
    input logic           tx_empty,
    input logic [NSS-1:0] ss_n
);
    assert_onehot_select_R10: assert property (@(posedge clk) disable iff (rst)
        !cfg_decode |-> ($countones(~ss_n) <= 1));

    assert_fault_clears_enable_R12: assert property (@(posedge clk) disable iff (rst)
        mode_fault |-> !dev_en);

    assert_enable_needs_write_R13: assert property (@(posedge clk) disable iff (rst)
        (!dev_en && !en_wr) |=> !dev_en);

    assert_rest_level_R3: assert property (@(posedge clk) disable iff (rst)
        (!dev_en && $past(!dev_en)) |-> (sclk == cfg_cpol));

    assert_clock_with_data_R6: assert property (@(posedge clk) disable iff (rst)
        (dev_en && $past(dev_en) && $stable(cfg_cpol) && (sclk != $past(sclk)))
        |-> !tx_empty);
endmodule

bind spi_fifo_master sfm_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_cpol   (cfg_cpol),
    .cfg_decode (cfg_decode),
    .en_wr      (en_wr),
    .dev_en     (dev_en),
    .mode_fault (mode_fault),
    .sclk       (sclk),
    .tx_empty   (tx_empty),
    .ss_n       (ss_n)
);

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb;
    import sfm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_cpol = 0, cfg_cpha = 0, cfg_decode = 0, cfg_force_cs = 0, cfg_manual_start = 0;
    logic [2:0] cfg_prescale = 3'd1;
    logic [2:0] cfg_sel = 3'd0;
    logic en_wr = 0, en_wdata = 0, start_cmd = 0, tx_push = 0, rx_pop = 0;
    logic [7:0] tx_data = 8'h00;
    logic tx_full, tx_empty, rx_empty, dev_en, mode_fault, sclk, mosi;
    logic [7:0] rx_data;
    logic [2:0] ss_n;
    logic miso = 1'b0;
    logic ss_in_n = 1'b1;
    logic slv_clear = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    int words_seen = 0;
    int fault_cnt = 0;
    int gmin = 1000000, gmax = 0;

    logic [7:0] exp_mosi[$];
    logic [7:0] resp_q[$];
    logic [7:0] exp_rx[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_fifo_master u_dut (
        .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_decode(cfg_decode), .cfg_force_cs(cfg_force_cs),
        .cfg_manual_start(cfg_manual_start), .cfg_prescale(cfg_prescale),
        .cfg_sel(cfg_sel), .en_wr(en_wr), .en_wdata(en_wdata),
        .start_cmd(start_cmd), .tx_push(tx_push), .tx_data(tx_data),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_pop(rx_pop),
        .rx_data(rx_data), .rx_empty(rx_empty), .dev_en(dev_en),
        .mode_fault(mode_fault), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
        .miso(miso), .ss_in_n(ss_in_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // slave model and scoreboard monitor
    logic       prev_sclk = 1'b0;
    logic [7:0] got = 8'h00;
    int         sbit = 0, oidx = 0, ecnt = 0, cyc = 0, last_edge = 0;

    always @(negedge clk) begin
        cyc++;
        if (mode_fault) fault_cnt++;
        if (rst || slv_clear) begin
            sbit = 0; oidx = 0; ecnt = 0;
            prev_sclk = sclk;
        end else if (sclk != prev_sclk) begin
            automatic bit leading = (sclk != cfg_cpol);
            automatic bit smp = cfg_cpha ? !leading : leading;
            if (ecnt != 0) begin
                if (cyc - last_edge < gmin) gmin = cyc - last_edge;
                if (cyc - last_edge > gmax) gmax = cyc - last_edge;
            end
            last_edge = cyc;
            ecnt = (ecnt + 1) % 16;
            if (smp) begin
                got = {got[6:0], mosi};
                sbit++;
                if (sbit == 8) begin
                    if (exp_mosi.size() == 0) begin
                        check(0, "R2", "unexpected byte on mosi", got, 0);
                    end else begin
                        automatic logic [7:0] e = exp_mosi.pop_front();
                        check(got == e, "R2/R4", "mosi byte", got, e);
                    end
                    if (resp_q.size() > 0) void'(resp_q.pop_front());
                    words_seen++;
                    sbit = 0;
                    oidx = 0;
                end
            end else if (sbit != 0) begin
                oidx++;
            end
            prev_sclk = sclk;
        end
        miso = (resp_q.size() > 0) ? resp_q[0][7 - oidx] : 1'b0;
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_en(input logic v);
        @(posedge clk); #1;
        en_wr = 1'b1; en_wdata = v;
        @(posedge clk); #1;
        en_wr = 1'b0;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1;
        start_cmd = 1'b1;
        @(posedge clk); #1;
        start_cmd = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] tx, input logic [7:0] resp);
        @(posedge clk); #1;
        exp_mosi.push_back(tx);
        resp_q.push_back(resp);
        exp_rx.push_back(resp);
        tx_push = 1'b1; tx_data = tx;
        @(posedge clk); #1;
        tx_push = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (tx_empty && exp_mosi.size() == 0) break;
        end
        cycles(4);
    endtask

    task automatic drain_rx(input string req);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (rx_empty) break;
            if (exp_rx.size() == 0) begin
                check(0, req, "extra received byte", rx_data, 0);
            end else begin
                automatic logic [7:0] e = exp_rx.pop_front();
                check(rx_data == e, req, "received byte", rx_data, e);
            end
            @(posedge clk); #1; rx_pop = 1'b1;
            @(posedge clk); #1; rx_pop = 1'b0;
        end
        check(exp_rx.size() == 0, req, "missing received bytes", exp_rx.size(), 0);
    endtask

    task automatic clr_gaps();
        gmin = 1000000; gmax = 0;
    endtask

    task automatic check_gaps(input string req, input int exp);
        check(gmin == exp && gmax == exp, req, "sclk edge spacing", gmax, exp);
    endtask

    task automatic reconfig(input logic cpol, input logic cpha, input logic [2:0] presc);
        set_en(1'b0);
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_prescale = presc;
        cycles(2);
        slv_clear = 1'b1; cycles(1); slv_clear = 1'b0;
        set_en(1'b1);
        cycles(2);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int base;
        cycles(5);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(ss_n == 3'b111, "R1", "ss_n after reset", ss_n, 7);
        check(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);
        check(dev_en == 1'b0, "R1", "dev_en after reset", dev_en, 0);
        check(rx_empty && tx_empty, "R1", "queues empty", {rx_empty, tx_empty}, 3);
        check(mode_fault == 1'b0, "R1", "mode_fault after reset", mode_fault, 0);

        // mode 0, code 1: auto select and auto start (R6, R8, R2, R5, R3)
        set_en(1'b1);
        @(negedge clk);
        check(sclk == 1'b0, "R3", "rest level cpol0", sclk, 0);
        check(ss_n == 3'b111, "R6", "no select while queue empty", ss_n, 7);
        clr_gaps();
        send_byte(8'hA5, 8'h3C);
        cycles(3);
        @(negedge clk);
        check(ss_n == 3'b110, "R6", "select active with data queued", ss_n, 6);
        wait_done();
        @(negedge clk);
        check(ss_n == 3'b111, "R6", "select released on empty queue", ss_n, 7);
        check(words_seen == 1, "R8", "auto start sent word", words_seen, 1);
        check_gaps("R5", 2);
        drain_rx("R2");

        // code 0 burst
        reconfig(1'b0, 1'b0, 3'd0);
        clr_gaps();
        send_byte(8'h01, 8'h80);
        send_byte(8'hFE, 8'h7F);
        send_byte(8'h96, 8'hC3);
        wait_done();
        check_gaps("R5", 2);
        drain_rx("R2");

        // mode 3, code 3
        reconfig(1'b1, 1'b1, 3'd3);
        @(negedge clk);
        check(sclk == 1'b1, "R3", "rest level cpol1", sclk, 1);
        clr_gaps();
        send_byte(8'h5A, 8'hE1);
        send_byte(8'h33, 8'h0F);
        wait_done();
        check_gaps("R5", 8);
        drain_rx("R4");
        @(negedge clk);
        check(sclk == 1'b1, "R3", "rest level after words", sclk, 1);

        // mode 1, code 2 and mode 2
        reconfig(1'b0, 1'b1, 3'd2);
        clr_gaps();
        send_byte(8'hC6, 8'h29);
        wait_done();
        check_gaps("R5", 4);
        drain_rx("R4");
        reconfig(1'b1, 1'b0, 3'd1);
        send_byte(8'h4B, 8'hD2);
        wait_done();
        drain_rx("R4");

        // manual start (R9)
        reconfig(1'b0, 1'b0, 3'd1);
        set_en(1'b0);
        cfg_manual_start = 1'b1;
        set_en(1'b1);
        base = words_seen;
        send_byte(8'h81, 8'h18);
        cycles(60);
        @(negedge clk);
        check(words_seen == base, "R9", "no word before start", words_seen, base);
        check(sclk == 1'b0 && !tx_empty, "R9", "idle with data held", {sclk, tx_empty}, 0);
        pulse_start();
        wait_done();
        check(words_seen == base + 1, "R9", "word after start", words_seen, base + 1);
        send_byte(8'h11, 8'h22);
        send_byte(8'h44, 8'h88);
        cycles(60);
        @(negedge clk);
        check(words_seen == base + 1, "R9", "new data needs new start", words_seen, base + 1);
        pulse_start();
        wait_done();
        check(words_seen == base + 3, "R9", "one start drains queue", words_seen, base + 3);
        drain_rx("R9");
        set_en(1'b0);
        cfg_manual_start = 1'b0;

        // forced select and select encodings (R7, R10, R11)
        cfg_force_cs = 1'b1; cfg_sel = 3'd1;
        set_en(1'b1);
        @(negedge clk);
        check(ss_n == 3'b101, "R7", "forced select sel1 on empty queue", ss_n, 5);
        cfg_sel = 3'd2;
        @(negedge clk);
        check(ss_n == 3'b011, "R10", "one-hot sel2", ss_n, 3);
        cfg_sel = 3'd3;
        @(negedge clk);
        check(ss_n == 3'b111, "R10", "sel3 drives nothing", ss_n, 7);
        cfg_decode = 1'b1; cfg_sel = 3'd6;
        @(negedge clk);
        check(ss_n == 3'b110, "R11", "decoder code forced", ss_n, 6);
        cfg_force_cs = 1'b0;
        @(negedge clk);
        check(ss_n == 3'b111, "R11", "decoder idle code", ss_n, 7);
        cfg_sel = 3'd5;
        send_byte(8'h3E, 8'hB7);
        cycles(3);
        @(negedge clk);
        check(ss_n == 3'b101, "R11", "decoder code during word", ss_n, 5);
        wait_done();
        drain_rx("R11");
        set_en(1'b0);
        cfg_decode = 1'b0; cfg_sel = 3'd0;

        // mode fault and resend (R12, R13)
        reconfig(1'b0, 1'b0, 3'd7);
        base = words_seen;
        send_byte(8'hC3, 8'h5A);
        cycles(300);
        begin
            int fb;
            fb = fault_cnt;
            ss_in_n = 1'b0;
            cycles(3);
            ss_in_n = 1'b1;
            cycles(5);
            @(negedge clk);
            check(dev_en == 1'b0, "R12", "enable cleared by fault", dev_en, 0);
            check(fault_cnt == fb + 1, "R12", "single fault pulse", fault_cnt, fb + 1);
            check(sclk == 1'b0, "R12", "sclk back at rest", sclk, 0);
            check(rx_empty == 1'b1, "R12", "no byte from aborted word", rx_empty, 1);
            check(tx_empty == 1'b0, "R13", "aborted byte kept queued", tx_empty, 0);
        end
        slv_clear = 1'b1; cycles(1); slv_clear = 1'b0;
        cycles(50);
        @(negedge clk);
        check(dev_en == 1'b0, "R13", "enable stays clear without write", dev_en, 0);
        check(words_seen == base, "R13", "nothing sent while disabled", words_seen, base);
        cfg_prescale = 3'd1;
        set_en(1'b1);
        wait_done();
        check(words_seen == base + 1, "R13", "aborted byte resent", words_seen, base + 1);
        drain_rx("R13");

        finish_run();
    end
endmodule